// File: doc/BRIEF.md
# Interrupt Request Prioritizer

This block picks one winner among a bus request, a non-maskable interrupt and a set of maskable interrupt requests for a small processor core. A core stub supplies two boundary strobes. The machine-cycle-end strobe is where a bus request can be honoured. The instruction-boundary strobe is where interrupts can be taken. The block applies a fixed priority at each strobe and reports the winner for one clock cycle after the strobe.

The request pins arrive as synchronous, active-low samples. The non-maskable line is edge triggered. It ignores the global enable and is held pending until a boundary takes it. The primary maskable line is level sensitive. The secondary maskable lines (a parameter, two by default) each have a trigger mode of their own. The block also reports the sampled levels of the secondary lines. A daisy-chain enable output is dropped while any interrupt taken here is in service, and it is released by a return-from-interrupt strobe.

Top module: `irq_prioritizer`

## Requirements
- R1: While `rst` is high, every output is held low, except `ext_level_o`, which is held at all ones.
- R2: When `mc_end_i` is high and `busreq_n_i` is low, the next cycle shows a grant of code 1 (bus). It beats any interrupt, including one that is pending at the same boundary. The grant is a single-cycle pulse.
- R3: An interrupt is granted only in the cycle after `instr_end_i` is high. No interrupt is granted while `busreq_n_i` is low, even at an instruction boundary.
- R4: A high-to-low transition on `nmi_n_i` makes a non-maskable request, whatever the value of `ie_i`. If the transition comes between boundaries, the request is kept until the next boundary. It is also taken when the transition falls in the same cycle as the boundary strobe. Its grant (code 2) puts 0x0066 on `vector_o`. One transition gives exactly one grant.
- R5: A low `int0_n_i` is granted as code 3 only when `ie_i` is high and no non-maskable request is pending. In that grant cycle both `ack_m1_o` and `ack_iorq_o` are high.
- R6: Secondary line k is granted as code 4+k only when `ie_i` is high, `int0_n_i` is high, and no bus or non-maskable request is present. A lower index wins over a higher one. Both acknowledge outputs stay low for these grants.
- R7: The 2-bit field `ext_mode_i[2k+1:2k]` sets the trigger mode of line k. 00 and 11 mean active-low level, with nothing latched. 01 means rising edge and 10 means falling edge. An edge-mode request is latched until it is granted.
- R8: `ext_level_o` shows the value of `int_ext_n_i` one cycle after it is sampled.
- R9: `ieo_o` is high only when `iei_i` was high and no interrupt is in service. An interrupt grant starts service and a bus grant does not. `reti_i` ends service. When a grant and `reti_i` come in the same cycle, service continues.
- R10: `grant_src_o` uses code 0 for no grant, and `grant_valid_o` is high exactly when the code is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busreq_n_i | input | 1 | Bus request, active low, level |
| nmi_n_i | input | 1 | Non-maskable request, falling edge |
| int0_n_i | input | 1 | Primary maskable request, active low level |
| int_ext_n_i | input | NEXT | Secondary maskable request pins |
| ext_mode_i | input | 2*NEXT | Trigger mode field for each secondary line |
| ie_i | input | 1 | Global maskable interrupt enable |
| mc_end_i | input | 1 | Machine-cycle-end strobe |
| instr_end_i | input | 1 | Instruction-boundary strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| iei_i | input | 1 | Daisy-chain enable in |
| grant_valid_o | output | 1 | Grant pulse |
| grant_src_o | output | SRC_W | Winning source code |
| ack_m1_o | output | 1 | Acknowledge, machine-cycle-one style |
| ack_iorq_o | output | 1 | Acknowledge, I/O-request style |
| vector_o | output | VEC_W | Fixed non-maskable target address during its grant |
| ext_level_o | output | NEXT | Sampled secondary pin levels |
| ieo_o | output | 1 | Daisy-chain enable out |

## Verification
Two things can land in the same cycle. The first is a non-maskable edge that arrives together with a boundary strobe. The bench drives the falling edge and the instruction strobe at the same clock edge while the primary line is also low and enabled. It expects the non-maskable grant, and then the primary grant at the next boundary with no second non-maskable grant. The second is a grant that coincides with a return-from-interrupt strobe. The bench expects the daisy-chain output to stay low until a later strobe that comes on its own. A bus request that meets a pending non-maskable edge at one strobe is also checked: the bus must win and the edge must survive to the next boundary.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    MODE_LEVEL = 2'b00,
    MODE_RISE  = 2'b01,
    MODE_FALL  = 2'b10,
    MODE_LVL2  = 2'b11
  } trig_mode_t;

  localparam int SRC_NONE = 0;
  localparam int SRC_BUS  = 1;
  localparam int SRC_NMI  = 2;
  localparam int SRC_INT0 = 3;
  localparam int SRC_EXT0 = 4;

  function automatic int src_width(input int n_ext);
    return $clog2(SRC_EXT0 + n_ext);
  endfunction
endpackage

// File: rtl/irq_trig_cell.sv
module irq_trig_cell
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_n,
  input  trig_mode_t mode,
  input  logic       take,
  output logic       req
);
  logic prev_q;
  logic lat_q;
  logic is_edge;
  logic hit;

  assign is_edge = (mode == MODE_RISE) || (mode == MODE_FALL);

  always_comb begin
    case (mode)
      MODE_RISE: hit = ~prev_q & pin_n;
      MODE_FALL: hit = prev_q & ~pin_n;
      default:   hit = 1'b0;
    endcase
  end

  // edge modes: a request seen in this cycle is visible at once; it is held until taken
  assign req = is_edge ? (lat_q | hit) : ~pin_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= pin_n;
      lat_q  <= is_edge ? ((lat_q | hit) & ~take) : 1'b0;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NEXT  = 2,
  parameter int SRC_W = 3
) (
  input  logic             mc_end,
  input  logic             instr_end,
  input  logic             ie,
  input  logic             bus_req,
  input  logic             nmi_req,
  input  logic             int0_req,
  input  logic [NEXT-1:0]  ext_req,
  output logic             win,
  output logic [SRC_W-1:0] win_src,
  output logic             take_nmi,
  output logic             take_int0,
  output logic [NEXT-1:0]  take_ext
);
  always_comb begin
    logic found;
    found     = 1'b0;
    win       = 1'b0;
    win_src   = SRC_W'(SRC_NONE);
    take_nmi  = 1'b0;
    take_int0 = 1'b0;
    take_ext  = '0;
    if (mc_end && bus_req) begin
      win     = 1'b1;
      win_src = SRC_W'(SRC_BUS);
    end else if (instr_end && !bus_req) begin
      if (nmi_req) begin
        win      = 1'b1;
        win_src  = SRC_W'(SRC_NMI);
        take_nmi = 1'b1;
      end else if (int0_req) begin
        if (ie) begin
          win       = 1'b1;
          win_src   = SRC_W'(SRC_INT0);
          take_int0 = 1'b1;
        end
      end else if (ie) begin
        for (int k = 0; k < NEXT; k++) begin
          if (ext_req[k] && !found) begin
            found       = 1'b1;
            win         = 1'b1;
            win_src     = SRC_W'(SRC_EXT0 + k);
            take_ext[k] = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/irq_service_track.sv
module irq_service_track (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic done,
  input  logic iei,
  output logic ieo
);
  logic svc_q;
  logic svc_d;

  // a new grant outranks a simultaneous return
  assign svc_d = start | (svc_q & ~done);

  always_ff @(posedge clk) begin
    if (rst) begin
      svc_q <= 1'b0;
      ieo   <= 1'b0;
    end else begin
      svc_q <= svc_d;
      ieo   <= iei & ~svc_d;
    end
  end
endmodule

// File: rtl/irq_prioritizer.sv
module irq_prioritizer
  import irq_pkg::*;
#(
  parameter int          NEXT    = 2,
  parameter int          VEC_W   = 16,
  parameter logic [15:0] NMI_VEC = 16'h0066,
  localparam int         SRC_W   = src_width(NEXT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busreq_n_i,
  input  logic              nmi_n_i,
  input  logic              int0_n_i,
  input  logic [NEXT-1:0]   int_ext_n_i,
  input  logic [2*NEXT-1:0] ext_mode_i,
  input  logic              ie_i,
  input  logic              mc_end_i,
  input  logic              instr_end_i,
  input  logic              reti_i,
  input  logic              iei_i,
  output logic              grant_valid_o,
  output logic [SRC_W-1:0]  grant_src_o,
  output logic              ack_m1_o,
  output logic              ack_iorq_o,
  output logic [VEC_W-1:0]  vector_o,
  output logic [NEXT-1:0]   ext_level_o,
  output logic              ieo_o
);
  logic             nmi_req;
  logic [NEXT-1:0]  ext_req;
  logic             win;
  logic [SRC_W-1:0] win_src;
  logic             take_nmi;
  logic             take_int0;
  logic [NEXT-1:0]  take_ext;
  logic             svc_start;

  irq_trig_cell u_nmi_cell (
    .clk   (clk),
    .rst   (rst),
    .pin_n (nmi_n_i),
    .mode  (MODE_FALL),
    .take  (take_nmi),
    .req   (nmi_req)
  );

  for (genvar k = 0; k < NEXT; k++) begin : g_ext
    irq_trig_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .pin_n (int_ext_n_i[k]),
      .mode  (trig_mode_t'(ext_mode_i[2*k +: 2])),
      .take  (take_ext[k]),
      .req   (ext_req[k])
    );
  end

  irq_arbiter #(.NEXT(NEXT), .SRC_W(SRC_W)) u_arb (
    .mc_end    (mc_end_i),
    .instr_end (instr_end_i),
    .ie        (ie_i),
    .bus_req   (~busreq_n_i),
    .nmi_req   (nmi_req),
    .int0_req  (~int0_n_i),
    .ext_req   (ext_req),
    .win       (win),
    .win_src   (win_src),
    .take_nmi  (take_nmi),
    .take_int0 (take_int0),
    .take_ext  (take_ext)
  );

  assign svc_start = take_nmi | take_int0 | (|take_ext);

  irq_service_track u_svc (
    .clk   (clk),
    .rst   (rst),
    .start (svc_start),
    .done  (reti_i),
    .iei   (iei_i),
    .ieo   (ieo_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid_o <= 1'b0;
      grant_src_o   <= '0;
      ack_m1_o      <= 1'b0;
      ack_iorq_o    <= 1'b0;
      vector_o      <= '0;
      ext_level_o   <= '1;
    end else begin
      grant_valid_o <= win;
      grant_src_o   <= win_src;
      ack_m1_o      <= take_int0;
      ack_iorq_o    <= take_int0;
      vector_o      <= take_nmi ? VEC_W'(NMI_VEC) : '0;
      ext_level_o   <= int_ext_n_i;
    end
  end
endmodule

// File: rtl/irq_prioritizer_chk.sv
module irq_prioritizer_chk
  import irq_pkg::*;
#(
  parameter int          NEXT    = 2,
  parameter int          VEC_W   = 16,
  parameter logic [15:0] NMI_VEC = 16'h0066,
  localparam int         SRC_W   = src_width(NEXT)
) (
  input logic             clk,
  input logic             rst,
  input logic             busreq_n_i,
  input logic             int0_n_i,
  input logic [NEXT-1:0]  int_ext_n_i,
  input logic             ie_i,
  input logic             mc_end_i,
  input logic             instr_end_i,
  input logic             iei_i,
  input logic             grant_valid_o,
  input logic [SRC_W-1:0] grant_src_o,
  input logic             ack_m1_o,
  input logic             ack_iorq_o,
  input logic [VEC_W-1:0] vector_o,
  input logic [NEXT-1:0]  ext_level_o,
  input logic             ieo_o
);
  assert_bus_at_cycle_end_R2: assert property (@(posedge clk) disable iff (rst)
    (grant_src_o == SRC_W'(SRC_BUS)) |-> $past(mc_end_i && !busreq_n_i));

  assert_int_at_boundary_R3: assert property (@(posedge clk) disable iff (rst)
    (grant_valid_o && grant_src_o != SRC_W'(SRC_BUS)) |-> $past(instr_end_i && busreq_n_i));

  assert_nmi_vector_R4: assert property (@(posedge clk) disable iff (rst)
    (vector_o != '0) == (grant_src_o == SRC_W'(SRC_NMI)));

  assert_int0_ack_pair_R5: assert property (@(posedge clk) disable iff (rst)
    (ack_m1_o || ack_iorq_o) |->
      (ack_m1_o && ack_iorq_o && grant_src_o == SRC_W'(SRC_INT0) && $past(ie_i)));

  assert_ext_gated_R6: assert property (@(posedge clk) disable iff (rst)
    (grant_valid_o && grant_src_o >= SRC_W'(SRC_EXT0)) |->
      ($past(ie_i && int0_n_i) && !ack_m1_o));

  assert_level_mirror_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ext_level_o == $past(int_ext_n_i)));

  assert_ieo_follows_iei_R9: assert property (@(posedge clk) disable iff (rst)
    ieo_o |-> $past(iei_i));

  assert_ieo_drops_on_int_R9: assert property (@(posedge clk) disable iff (rst)
    (grant_valid_o && grant_src_o != SRC_W'(SRC_BUS)) |-> !ieo_o);

  assert_code_valid_R10: assert property (@(posedge clk) disable iff (rst)
    grant_valid_o == (grant_src_o != '0));
endmodule

bind irq_prioritizer irq_prioritizer_chk #(.NEXT(NEXT), .VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .busreq_n_i    (busreq_n_i),
  .int0_n_i      (int0_n_i),
  .int_ext_n_i   (int_ext_n_i),
  .ie_i          (ie_i),
  .mc_end_i      (mc_end_i),
  .instr_end_i   (instr_end_i),
  .iei_i         (iei_i),
  .grant_valid_o (grant_valid_o),
  .grant_src_o   (grant_src_o),
  .ack_m1_o      (ack_m1_o),
  .ack_iorq_o    (ack_iorq_o),
  .vector_o      (vector_o),
  .ext_level_o   (ext_level_o),
  .ieo_o         (ieo_o)
);

// File: tb/irq_prioritizer_tb_top.sv
`timescale 1ns/1ps
module irq_prioritizer_tb_top;
  localparam int NEXT  = 2;
  localparam int SRC_W = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              busreq_n_i = 1'b1;
  logic              nmi_n_i = 1'b1;
  logic              int0_n_i = 1'b1;
  logic [NEXT-1:0]   int_ext_n_i = '1;
  logic [2*NEXT-1:0] ext_mode_i = '0;
  logic              ie_i = 1'b0;
  logic              mc_end_i = 1'b0;
  logic              instr_end_i = 1'b0;
  logic              reti_i = 1'b0;
  logic              iei_i = 1'b1;
  logic              grant_valid_o;
  logic [SRC_W-1:0]  grant_src_o;
  logic              ack_m1_o;
  logic              ack_iorq_o;
  logic [15:0]       vector_o;
  logic [NEXT-1:0]   ext_level_o;
  logic              ieo_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  irq_prioritizer #(.NEXT(NEXT)) dut_i (
    .clk(clk), .rst(rst), .busreq_n_i(busreq_n_i), .nmi_n_i(nmi_n_i),
    .int0_n_i(int0_n_i), .int_ext_n_i(int_ext_n_i), .ext_mode_i(ext_mode_i),
    .ie_i(ie_i), .mc_end_i(mc_end_i), .instr_end_i(instr_end_i),
    .reti_i(reti_i), .iei_i(iei_i), .grant_valid_o(grant_valid_o),
    .grant_src_o(grant_src_o), .ack_m1_o(ack_m1_o), .ack_iorq_o(ack_iorq_o),
    .vector_o(vector_o), .ext_level_o(ext_level_o), .ieo_o(ieo_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive strobes for one cycle; on return the outputs show that boundary
  task automatic boundary(input logic mc, input logic ins);
    mc_end_i = mc;
    instr_end_i = ins;
    @(negedge clk);
    mc_end_i = 1'b0;
    instr_end_i = 1'b0;
  endtask

  task automatic expect_grant(input string tag, input logic v, input int src);
    chk({tag, " valid"}, 32'(grant_valid_o), 32'(v));
    chk({tag, " code R10"}, 32'(grant_src_o), 32'(src));
  endtask

  task automatic do_reti();
    reti_i = 1'b1;
    @(negedge clk);
    reti_i = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    idle(3);
    chk("R1 valid", 32'(grant_valid_o), 0);
    chk("R1 code", 32'(grant_src_o), 0);
    chk("R1 acks", 32'({ack_m1_o, ack_iorq_o}), 0);
    chk("R1 vector", 32'(vector_o), 0);
    chk("R1 ieo", 32'(ieo_o), 0);
    chk("R1 level", 32'(ext_level_o), 32'h3);
    rst = 1'b0;
    idle(1);
  endtask

  task automatic t_bus_then_int0();
    ie_i = 1'b1; int0_n_i = 1'b0; busreq_n_i = 1'b0;
    boundary(1'b1, 1'b1);
    expect_grant("R2 bus beats int0", 1'b1, 1);
    chk("R2 no ack on bus", 32'(ack_m1_o), 0);
    idle(1);
    chk("R2 single pulse", 32'(grant_valid_o), 0);
    boundary(1'b0, 1'b1);
    expect_grant("R3 bus blocks int", 1'b0, 0);
    busreq_n_i = 1'b1;
    idle(3);
    chk("R3 no strobe no grant", 32'(grant_valid_o), 0);
    chk("R9 ieo idle", 32'(ieo_o), 1);
    boundary(1'b0, 1'b1);
    expect_grant("R5 int0", 1'b1, 3);
    chk("R5 both acks", 32'({ack_m1_o, ack_iorq_o}), 32'h3);
    chk("R9 ieo in service", 32'(ieo_o), 0);
    int0_n_i = 1'b1;
    do_reti();
    chk("R9 ieo after reti", 32'(ieo_o), 1);
  endtask

  task automatic t_int0_masked();
    ie_i = 1'b0; int0_n_i = 1'b0;
    boundary(1'b0, 1'b1);
    expect_grant("R5 masked int0", 1'b0, 0);
    int0_n_i = 1'b1;
    idle(1);
  endtask

  task automatic t_nmi();
    ie_i = 1'b0;
    nmi_n_i = 1'b0; idle(1);
    nmi_n_i = 1'b1; idle(3);
    boundary(1'b0, 1'b1);
    expect_grant("R4 held nmi", 1'b1, 2);
    chk("R4 vector", 32'(vector_o), 32'h0066);
    boundary(1'b0, 1'b1);
    expect_grant("R4 one grant per edge", 1'b0, 0);
    chk("R4 vector cleared", 32'(vector_o), 0);
    do_reti();
    // same-cycle edge and boundary, with int0 competing
    ie_i = 1'b1; int0_n_i = 1'b0; nmi_n_i = 1'b0;
    boundary(1'b0, 1'b1);
    expect_grant("R4 same-cycle nmi", 1'b1, 2);
    boundary(1'b0, 1'b1);
    expect_grant("R5 int0 after nmi", 1'b1, 3);
    int0_n_i = 1'b1; nmi_n_i = 1'b1;
    do_reti();
    // bus outranks a pending nmi edge, which survives
    busreq_n_i = 1'b0; nmi_n_i = 1'b0; idle(1);
    boundary(1'b1, 1'b1);
    expect_grant("R2 bus over nmi", 1'b1, 1);
    busreq_n_i = 1'b1; nmi_n_i = 1'b1; idle(1);
    boundary(1'b0, 1'b1);
    expect_grant("R4 nmi kept over bus", 1'b1, 2);
    do_reti();
  endtask

  task automatic t_ext_priority();
    ext_mode_i = 4'b0000; ie_i = 1'b1;
    int_ext_n_i = 2'b00;
    boundary(1'b0, 1'b1);
    expect_grant("R6 line0 first", 1'b1, 4);
    chk("R6 no ack", 32'({ack_m1_o, ack_iorq_o}), 0);
    int_ext_n_i = 2'b01;
    boundary(1'b0, 1'b1);
    expect_grant("R6 line1", 1'b1, 5);
    int_ext_n_i = 2'b00; int0_n_i = 1'b0;
    boundary(1'b0, 1'b1);
    expect_grant("R6 int0 over ext", 1'b1, 3);
    int0_n_i = 1'b1; ie_i = 1'b0;
    boundary(1'b0, 1'b1);
    expect_grant("R6 masked ext", 1'b0, 0);
    int_ext_n_i = 2'b11;
    do_reti();
  endtask

  task automatic t_edge_modes();
    ie_i = 1'b1;
    ext_mode_i = 4'b1001; // line1 falling, line0 rising
    int_ext_n_i[0] = 1'b0; idle(1);
    int_ext_n_i[0] = 1'b1; idle(2);
    boundary(1'b0, 1'b1);
    expect_grant("R7 rising latched", 1'b1, 4);
    boundary(1'b0, 1'b1);
    expect_grant("R7 rising cleared", 1'b0, 0);
    int_ext_n_i[1] = 1'b0; idle(1);
    int_ext_n_i[1] = 1'b1; idle(2);
    boundary(1'b0, 1'b1);
    expect_grant("R7 falling latched", 1'b1, 5);
    ext_mode_i = 4'b0000;
    int_ext_n_i[0] = 1'b0; idle(1);
    int_ext_n_i[0] = 1'b1; idle(1);
    boundary(1'b0, 1'b1);
    expect_grant("R7 level not latched", 1'b0, 0);
    ext_mode_i = 4'b0011;
    int_ext_n_i[0] = 1'b0;
    boundary(1'b0, 1'b1);
    expect_grant("R7 mode 11 is level", 1'b1, 4);
    int_ext_n_i = 2'b11; ext_mode_i = 4'b0000; ie_i = 1'b0;
    do_reti();
  endtask

  task automatic t_level_readback();
    int_ext_n_i = 2'b10; idle(1);
    chk("R8 level 10", 32'(ext_level_o), 32'h2);
    int_ext_n_i = 2'b01; idle(1);
    chk("R8 level 01", 32'(ext_level_o), 32'h1);
    int_ext_n_i = 2'b11; idle(1);
  endtask

  task automatic t_ieo();
    iei_i = 1'b0; idle(1);
    chk("R9 iei low", 32'(ieo_o), 0);
    iei_i = 1'b1; idle(1);
    chk("R9 iei high", 32'(ieo_o), 1);
    ie_i = 1'b1; int0_n_i = 1'b0; reti_i = 1'b1;
    boundary(1'b0, 1'b1);
    reti_i = 1'b0; int0_n_i = 1'b1;
    chk("R9 grant beats reti", 32'(ieo_o), 0);
    idle(1);
    chk("R9 still in service", 32'(ieo_o), 0);
    do_reti();
    chk("R9 released", 32'(ieo_o), 1);
    busreq_n_i = 1'b0;
    boundary(1'b1, 1'b0);
    busreq_n_i = 1'b1;
    expect_grant("R2 bus grant", 1'b1, 1);
    chk("R9 bus keeps ieo", 32'(ieo_o), 1);
  endtask

  initial begin
    idle(1);
    t_reset();
    t_bus_then_int0();
    t_int0_masked();
    t_nmi();
    t_ext_priority();
    t_edge_modes();
    t_level_readback();
    t_ieo();
    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule